// File: doc/BRIEF.md
# Pipelined Converter Output Correction Logic

This block turns the raw decisions of a pipelined analog-to-digital converter into one corrected output word per sample. The converter has eight redundant stages, each resolving its input into five regions with four comparators, followed by a 2-bit final flash quantiser. Each stage delivers its comparator outputs as a 4-bit thermometer pattern. The block reduces that pattern to a count from 0 to 4.

A stage resolves its part of a sample one clock after the stage before it. The block therefore delays the early decisions so that all nine codes of one sample arrive together. It then adds the stage codes, each shifted to its binary weight, and removes one unit per stage in a single constant correction. That constant also carries a leading one, which keeps the result from going negative.

The result is a 12-bit word. The low ten bits are the conversion value and the top two bits tell whether the input was within the reference range, above it or below it. A new sample can enter on every clock. The output strobe follows the first stage's decision by a fixed nine cycles.

Top module: `pipe_adc_corrector`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) drives out_valid to 0 and out_code to 0.
- R2: Stage s (1..8) presents its four comparator outputs on stage_thermo[4s-1:4s-4]. The stage value is the number of ones in that field, so a non-thermometer (bubble) pattern such as 4'b1010 counts as 2.
- R3: For one sample, stage s's field is presented s-1 cycles after stage 1's field, and flash_code is presented 8 cycles after stage 1's field. in_valid accompanies stage 1. out_valid is high exactly 9 cycles after in_valid was high.
- R4: With stage values c1..c8 and flash value f, let S = sum over s of (c_s - 1) * 2^(9-s), plus f. Then out_code = (S + 2048) mod 4096.
- R5: When 0 <= S <= 1023, out_code[11:10] = 2'b10 and out_code[9:0] = S.
- R6: When S > 1023 (input above range), out_code[11:10] = 2'b11.
- R7: When S < 0 (input below range), out_code[11:10] = 2'b01. A valid output never carries 2'b00 in the top bits.
- R8: Samples presented on consecutive cycles emerge on consecutive cycles, each with its own correct value.
- R9: While out_valid is low, out_code keeps the last corrected value.
- R10: A reset drops every sample in flight. After reset, out_valid stays low until a sample presented after the reset has completed its 9-cycle path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Stage 1 decision of a new sample is present |
| stage_thermo | input | 32 | Comparator outputs, 4 per stage, stage 1 in the low bits |
| flash_code | input | 2 | Binary code of the final flash quantiser |
| out_valid | output | 1 | out_code holds a newly corrected sample |
| out_code | output | 12 | Range flags [11:10] and conversion value [9:0] |

## Verification
Vectors with every stage at the same value cover the whole sum range: all ones give the mid value, all twos a mid-range positive value, all fours the top of the overflow region, and all zeros the bottom of the underflow region. Vectors that move one or two stages, and vectors placed at S = 1023, 1024 and -1, check that each stage carries its own weight and that the flags switch at the range edges. All vectors run back to back with the stage skew applied, so a deskew depth that is wrong by one cycle mixes neighbouring samples and shows up in the output. Bubble patterns that have the same count as a clean code must give the same output. A single isolated sample and a reset that interrupts samples in flight check the exact latency and the flushing of the pipeline.

// File: rtl/adc_corr_pkg.sv
// Package: shared constants and helpers for the pipelined converter
// output correction logic.
// Assumes: each stage resolves five regions, so its value lies in 0..4.
package adc_corr_pkg;

    // Width of a count that can hold 0..n.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Sum of the stage weights 2^(fb-1) .. 2^(nstg+fb-2): one unit per stage to remove.
    function automatic int unit_sum(input int nstg, input int fb);
        return (1 << (nstg + fb - 1)) - (1 << (fb - 1));
    endfunction

    // Constant added after the shifted sum: the leading one minus the per-stage units.
    function automatic int corr_bias(input int nstg, input int fb);
        return (1 << (nstg + fb + 1)) - unit_sum(nstg, fb);
    endfunction

endpackage

// File: rtl/therm_count.sv
// Module: therm_count
// Reduces one stage's comparator outputs to the number of tripped
// comparators. Bubbles in the thermometer pattern are resolved by
// counting ones, so the result never depends on bit order.
// Assumes: purely combinational; registered by the caller.
module therm_count #(
    parameter int NCMP = 4,
    localparam int CW  = adc_corr_pkg::count_width(NCMP)
) (
    input  logic [NCMP-1:0] thermo,
    output logic [CW-1:0]   count
);

    // Count the ones, one comparator at a time.
    always_comb begin
        count = '0;
        for (int i = 0; i < NCMP; i++) begin
            count = count + CW'(thermo[i]);
        end
    end

    // R2: the stage value is the number of tripped comparators.
    always_comb begin
        a_r2_ones_count : assert (32'(count) == 32'($countones(thermo)))
            else $error("R2: stage count disagrees with the comparator pattern");
    end

endmodule

// File: rtl/skew_line.sv
// Module: skew_line
// Fixed-depth delay line used to line up the decisions of one sample.
// A depth of zero is a plain wire.
// Assumes: synchronous active-low reset clears every tap.
module skew_line #(
    parameter int W     = 3,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] tap [DEPTH];

            // Shift the value one tap further each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
                end else begin
                    tap[0] <= din;
                    for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
                end
            end

            assign dout = tap[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/overlap_sum.sv
// Module: overlap_sum
// Adds the aligned stage values, each shifted to its binary weight,
// adds the flash code, then applies one constant that removes one unit
// per stage and inserts the leading one.
// Assumes: stage 1 is the lowest field of codes and carries the
// largest weight. With NCMP = 4 the sum stays below 2^OUT_W.
module overlap_sum #(
    parameter int NSTG  = 8,
    parameter int NCMP  = 4,
    parameter int FB    = 2,
    localparam int CW   = adc_corr_pkg::count_width(NCMP),
    localparam int OUT_W = NSTG + FB + 2
) (
    input  logic [NSTG*CW-1:0] codes,
    input  logic [FB-1:0]      flash,
    output logic [OUT_W-1:0]   word
);

    localparam int BIAS = adc_corr_pkg::corr_bias(NSTG, FB);

    // Shifted addition first, then the combined subtract-one and offset.
    always_comb begin
        word = OUT_W'(flash);
        for (int i = 0; i < NSTG; i++) begin
            word = word + (OUT_W'(codes[i*CW +: CW]) << (NSTG - i + FB - 2));
        end
        word = word + OUT_W'(BIAS);
    end

endmodule

// File: rtl/pipe_adc_corrector.sv
// Module: pipe_adc_corrector (top)
// Deskews the per-stage decisions of a pipelined converter, combines
// them with overlapped addition and registers one 12-bit word per
// sample with range flags in the top two bits.
// Assumes: stage s of a sample arrives s-1 cycles after stage 1, and
// the flash 8 cycles after; in_valid travels with stage 1.
module pipe_adc_corrector #(
    parameter int NSTG = 8,
    parameter int NCMP = 4,
    parameter int FB   = 2,
    localparam int CW    = adc_corr_pkg::count_width(NCMP),
    localparam int OUT_W = NSTG + FB + 2,
    localparam int LAT   = NSTG + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [NSTG*NCMP-1:0] stage_thermo,
    input  logic [FB-1:0]        flash_code,
    output logic                 out_valid,
    output logic [OUT_W-1:0]     out_code
);

    logic [NSTG*CW-1:0] aligned;
    logic [FB-1:0]      flash_al;
    logic               valid_al;
    logic [OUT_W-1:0]   sum_word;

    // One decoder and one delay line per stage; early stages wait longest.
    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stage
            logic [CW-1:0] raw;

            therm_count #(.NCMP(NCMP)) u_count (
                .thermo (stage_thermo[s*NCMP +: NCMP]),
                .count  (raw)
            );

            skew_line #(.W(CW), .DEPTH(NSTG - s)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (raw),
                .dout  (aligned[s*CW +: CW])
            );
        end
    endgenerate

    // The flash arrives last and needs no delay.
    skew_line #(.W(FB), .DEPTH(0)) u_flash_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (flash_code),
        .dout  (flash_al)
    );

    // Valid strobe follows stage 1 through the same depth.
    skew_line #(.W(1), .DEPTH(NSTG)) u_valid_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (in_valid),
        .dout  (valid_al)
    );

    overlap_sum #(.NSTG(NSTG), .NCMP(NCMP), .FB(FB)) u_sum (
        .codes (aligned),
        .flash (flash_al),
        .word  (sum_word)
    );

    // Output register: load only for a complete sample, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= valid_al;
            if (valid_al) out_code <= sum_word;
        end
    end

    // ---------------- assertions ----------------
    logic [4:0] since_rst;

    // Cycles since the last reset, saturating; used by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (~&since_rst)    since_rst <= since_rst + 5'd1;
    end

    // R1: reset leaves the output idle and cleared.
    a_r1_reset_clears : assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (!out_valid && out_code == '0))
        else $error("R1: output not cleared by reset");

    // R7: a valid word never carries the unused flag value 00.
    a_r7_no_zero_flag : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code[OUT_W-1:OUT_W-2] != 2'b00))
        else $error("R7: flag bits 00 on a valid word");

    // R9: without a new sample the word is held.
    a_r9_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && since_rst != '0) |-> $stable(out_code))
        else $error("R9: out_code changed without out_valid");

    // R10: nothing valid leaves before a post-reset sample could finish.
    a_r10_flush : assert property (@(posedge clk) disable iff (!rst_n)
        (32'(since_rst) < LAT) |-> !out_valid)
        else $error("R10: out_valid too soon after reset");

    generate
        if (NSTG == 8) begin : g_lat_chk
            // R3: strobe appears exactly 9 cycles after in_valid.
            a_r3_latency_fwd : assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= 5'd9 && $past(in_valid, 9)) |-> out_valid)
                else $error("R3: expected out_valid missing");

            a_r3_latency_back : assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= 5'd9 && out_valid) |-> $past(in_valid, 9))
                else $error("R3: out_valid without matching input");
        end
    endgenerate

endmodule

// File: tb/test_pipe_adc_corrector.sv
`timescale 1ns/1ps
module test_pipe_adc_corrector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] stage_thermo = '0;
    logic [1:0]  flash_code = '0;
    logic        out_valid;
    logic [11:0] out_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pipe_adc_corrector i_pipe_adc_corrector (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .stage_thermo (stage_thermo),
        .flash_code   (flash_code),
        .out_valid    (out_valid),
        .out_code     (out_code)
    );

    // Vector table: stage values 1..8, flash value, expected word (R4).
    localparam int NV = 9;
    localparam int VC [NV][8] = '{
        '{1,1,1,1,1,1,1,1},   // S = 0
        '{2,2,2,2,2,2,2,2},   // S = 513 with flash 3
        '{4,4,4,4,4,4,4,4},   // S = 1533, above range
        '{0,0,0,0,0,0,0,0},   // S = -510, below range
        '{2,1,1,1,1,1,1,1},   // S = 256
        '{3,0,1,1,1,1,1,1},   // S = 385
        '{3,3,3,3,3,3,3,3},   // S = 1023, top of range
        '{4,3,1,1,1,1,1,1},   // S = 1024, first overflow
        '{1,1,1,1,1,1,1,0}    // S = -1, first underflow
    };
    localparam int VF [NV] = '{0, 3, 3, 0, 0, 1, 3, 0, 1};
    localparam logic [11:0] VE [NV] = '{
        12'h800, 12'hA01, 12'hDFD, 12'h602, 12'h900,
        12'h981, 12'hBFF, 12'hC00, 12'h7FF
    };
    localparam string VT [NV] = '{
        "R5", "R5", "R6", "R7", "R5", "R5", "R5", "R6", "R7"
    };

    // Working stream buffers.
    logic [3:0]  seq_th  [16][8];
    logic [1:0]  seq_fl  [16];
    logic [11:0] seq_exp [16];
    string       seq_tag [16];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] therm(input int c);
        return 4'((1 << c) - 1);
    endfunction

    // Drives n samples back to back with the stage skew and checks each output cycle.
    task automatic run_stream(input int n);
        for (int t = 0; t < n + 10; t++) begin
            for (int k = 0; k < 8; k++) begin
                stage_thermo[k*4 +: 4] = (t - k >= 0 && t - k < n) ? seq_th[t-k][k] : 4'b0;
            end
            flash_code = (t - 8 >= 0 && t - 8 < n) ? seq_fl[t-8] : 2'b0;
            in_valid   = (t < n);
            @(negedge clk);
            begin
                int s;
                s = t - 8;
                check("R3/R8 out_valid", 32'(out_valid), 32'(s >= 0 && s < n));
                if (s >= 0 && s < n) begin
                    check({"R4/", seq_tag[s]}, 32'(out_code), 32'(seq_exp[s]));
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_code", 32'(out_code), 32'd0);
        rst_n = 1'b1;

        // Table walk, back to back (R4..R8).
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 8; k++) seq_th[v][k] = therm(VC[v][k]);
            seq_fl[v]  = 2'(VF[v]);
            seq_exp[v] = VE[v];
            seq_tag[v] = VT[v];
        end
        run_stream(NV);

        // R9: last word is held while idle.
        repeat (3) @(negedge clk);
        check("R9 hold valid", 32'(out_valid), 32'd0);
        check("R9 hold code", 32'(out_code), 32'h7FF);

        // R2: bubble patterns with the same count as clean codes.
        for (int k = 0; k < 8; k++) begin
            seq_th[0][k] = 4'b0001;
            seq_th[1][k] = 4'b0001;
        end
        seq_th[0][0] = 4'b1010;          // counts as 2 -> S = 256
        seq_th[1][1] = 4'b0100;          // counts as 1 -> S = 0
        seq_th[1][5] = 4'b1000;          // counts as 1
        seq_fl[0] = 2'd0; seq_fl[1] = 2'd0;
        seq_exp[0] = 12'h900; seq_exp[1] = 12'h800;
        seq_tag[0] = "R2"; seq_tag[1] = "R2";
        run_stream(2);

        // R3: isolated sample, output only in the ninth cycle.
        for (int k = 0; k < 8; k++) seq_th[0][k] = therm(2);
        seq_fl[0] = 2'd3; seq_exp[0] = 12'hA01; seq_tag[0] = "R3";
        run_stream(1);

        // R10: reset with samples in flight drops them.
        in_valid = 1'b1;
        stage_thermo = {8{4'b0011}};
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        stage_thermo = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 code after reset", 32'(out_code), 32'd0);
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            check("R10 no stale valid", 32'(out_valid), 32'd0);
        end

        // Fresh sample after reset still completes (R10).
        for (int k = 0; k < 8; k++) seq_th[0][k] = therm(1);
        seq_fl[0] = 2'd0; seq_exp[0] = 12'h800; seq_tag[0] = "R10";
        run_stream(1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule